// File: doc/BRIEF.md
# DLL Delay-Code Controller with Lock Timer

This block is the digital core of a delay-locked loop that follows a reference clock. An external phase detector reports on each cycle whether the delay should grow or shrink. The block keeps a 7-bit unsigned tap count and steps it by one in the requested direction. It publishes that count to the delay chains as a registered Gray-coded word, so a one-step update flips a single wire. Two more Gray-coded settings are produced from the same count. Each one adds its own signed offset and is clamped to the legal tap range.

A lock timer holds `locked` and `settings_valid` low until the loop has had time to settle. The wait is 256 reference cycles in normal mode and 1,280 cycles in low-jitter mode. The timer starts again after reset, after a `restart` pulse, and whenever the mode input changes. The timer is a two-state machine. `ST_SETTLE` counts cycles and `ST_LOCKED` holds the flags high. Its transitions are:
- T_SETTLE_DONE: `ST_SETTLE` to `ST_LOCKED` when the count reaches the mode's limit.
- T_RESTART: any state back to `ST_SETTLE` with the timer at zero when `restart` is high.
- T_MODE_CHANGE: any state back to `ST_SETTLE` with the timer at zero when `low_jitter` differs from the mode latched on the previous edge.

Top module: `dll_code_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the tap count is set to 64. `base_gray`, `tap_a_gray` and `tap_b_gray` all read 7'h60, which is the Gray code of 64. `locked` and `settings_valid` read 0.
- R2: At each edge, the tap count rises by one when only `pd_up` is high and falls by one when only `pd_dn` is high. It holds when both are high or both are low.
- R3: The tap count saturates at 127 and at 0 and never wraps.
- R4: `base_gray` equals b ^ (b >> 1), where b is the tap count. It is registered, so a count change at edge k appears on `base_gray` after edge k+1.
- R5: `tap_a_gray` and `tap_b_gray` are the Gray code of the count plus `offset_a` or `offset_b`. Each offset is read as 7-bit two's complement. Sums below 0 give 0 and sums above 127 give 127. The result is registered one edge after the inputs.
- R6: With `low_jitter` = 0, `locked` goes high right after the 256th clock edge that follows reset release or a restart or mode-change edge. Before that it is low.
- R7: With `low_jitter` = 1, `locked` goes high right after the 1,280th such edge and not before.
- R8: `restart` high at an edge drops `locked` after that edge and starts the lock wait again from zero.
- R9: A change of `low_jitter` at an edge drops `locked` after that edge. The wait then starts again from zero with the new mode's length.
- R10: `settings_valid` is low for the whole lock wait and equals `locked` at every cycle.
- R11: Between two consecutive cycles, `base_gray` changes in at most one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Restart the lock wait |
| low_jitter | input | 1 | 1 selects the long low-jitter lock wait |
| pd_up | input | 1 | Phase detector asks for more delay |
| pd_dn | input | 1 | Phase detector asks for less delay |
| offset_a | input | 7 | Signed offset for setting A |
| offset_b | input | 7 | Signed offset for setting B |
| base_gray | output | 7 | Gray-coded tracked tap count |
| tap_a_gray | output | 7 | Gray-coded, clamped count plus offset A |
| tap_b_gray | output | 7 | Gray-coded, clamped count plus offset B |
| locked | output | 1 | Lock wait has elapsed |
| settings_valid | output | 1 | Settings may be used downstream |

## Verification
A phase-detector request sampled at edge k changes the count at that edge. The Gray outputs show the change only after edge k+1. The bench therefore checks that the output is still unchanged one cycle after a request and correct one cycle later. An offset change shows on its tap output after one edge. The lock flags are checked at exactly N-1 and N edges after the releasing event, for both wait lengths. All inputs are driven and all outputs are sampled on the falling clock edge, so every expected value maps to a known count of rising edges.

// File: rtl/dll_pkg.sv
package dll_pkg;

    localparam int NUM_TAPS = 2;

    typedef enum logic {
        ST_SETTLE = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/dll_track_counter.sv
module dll_track_counter
    import dll_pkg::*;
#(
    parameter int W   = 7,
    parameter int MID = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pd_up,
    input  logic         pd_dn,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_MIN = '0;
    localparam logic [W-1:0] CNT_MID = W'(MID);

    step_dir_e    dir;
    logic [W-1:0] cnt_q;

    always_comb begin
        unique case ({pd_up, pd_dn})
            2'b10:   dir = DIR_UP;
            2'b01:   dir = DIR_DOWN;
            default: dir = DIR_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MID;
        end else begin
            unique case (dir)
                DIR_UP:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                DIR_DOWN: if (cnt_q != CNT_MIN) cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 7'd1) || (cnt_q == $past(cnt_q) - 7'd1)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_up == pd_dn) |=> $stable(cnt_q)); // R2
    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_up && !pd_dn && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R3
    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_dn && !pd_up && cnt_q == CNT_MIN) |=> (cnt_q == CNT_MIN)); // R3

endmodule

// File: rtl/dll_tap_encoder.sv
module dll_tap_encoder #(
    parameter int W          = 7,
    parameter int MID        = 64,
    parameter bit CHECK_STEP = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] offset_i,
    output logic [W-1:0] gray_o
);

    localparam logic [W-1:0] MID_BIN  = W'(MID);
    localparam logic [W-1:0] MID_GRAY = MID_BIN ^ (MID_BIN >> 1);

    logic signed [W+1:0] sum;
    logic [W-1:0]        clamped;
    logic [W-1:0]        gray_q;

    always_comb begin
        sum = $signed({2'b00, base_i}) + $signed({{2{offset_i[W-1]}}, offset_i});
        if (sum[W+1]) begin
            clamped = '0;
        end else if (sum[W]) begin
            clamped = '1;
        end else begin
            clamped = sum[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gray_q <= MID_GRAY;
        end else begin
            gray_q <= clamped ^ (clamped >> 1);
        end
    end

    assign gray_o = gray_q;

    generate
        if (CHECK_STEP) begin : g_step_chk
            AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(gray_q ^ $past(gray_q)) <= 1); // R11
        end
    endgenerate

endmodule

// File: rtl/dll_lock_fsm.sv
module dll_lock_fsm
    import dll_pkg::*;
#(
    parameter int LOCK_STD = 256,
    parameter int LOCK_LJ  = 1280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic low_jitter,
    output logic locked_o,
    output logic valid_o
);

    localparam int LONGEST = (LOCK_LJ > LOCK_STD) ? LOCK_LJ : LOCK_STD;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] LAST_STD = TW'(LOCK_STD - 1);
    localparam logic [TW-1:0] LAST_LJ  = TW'(LOCK_LJ - 1);

    lock_state_e   state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic [TW-1:0] tmr_last;
    logic          mode_q;
    logic          clear;
    logic          locked_q, valid_q;

    assign tmr_last = mode_q ? LAST_LJ : LAST_STD;
    assign clear    = restart || (low_jitter != mode_q);

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            ST_SETTLE: begin
                if (clear) begin
                    tmr_d = '0;
                end else if (tmr_q == tmr_last) begin
                    state_d = ST_LOCKED;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            ST_LOCKED: begin
                if (clear) begin
                    state_d = ST_SETTLE;
                    tmr_d   = '0;
                end
            end
            default: begin
                state_d = ST_SETTLE;
                tmr_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            tmr_q   <= '0;
            mode_q  <= low_jitter;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            mode_q  <= low_jitter;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            locked_q <= (state_d == ST_LOCKED);
            valid_q  <= (state_d == ST_LOCKED);
        end
    end

    assign locked_o = locked_q;
    assign valid_o  = valid_q;

    AST_LOCK_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> ($past(tmr_q) == $past(tmr_last))); // R6 R7
    AST_RESTART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked_q); // R8
    AST_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (low_jitter != mode_q) |=> (!locked_q && tmr_q == '0)); // R9
    AST_VALID_LOW_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> !valid_q); // R10

endmodule

// File: rtl/dll_code_ctrl.sv
module dll_code_ctrl
    import dll_pkg::*;
#(
    parameter int W        = 7,
    parameter int MID      = 64,
    parameter int LOCK_STD = 256,
    parameter int LOCK_LJ  = 1280
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         low_jitter,
    input  logic         pd_up,
    input  logic         pd_dn,
    input  logic [W-1:0] offset_a,
    input  logic [W-1:0] offset_b,
    output logic [W-1:0] base_gray,
    output logic [W-1:0] tap_a_gray,
    output logic [W-1:0] tap_b_gray,
    output logic         locked,
    output logic         settings_valid
);

    logic [W-1:0] cnt;
    logic [W-1:0] off_arr  [NUM_TAPS];
    logic [W-1:0] gray_arr [NUM_TAPS];

    assign off_arr[0] = offset_a;
    assign off_arr[1] = offset_b;

    dll_track_counter #(.W(W), .MID(MID)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .pd_up (pd_up),
        .pd_dn (pd_dn),
        .cnt_o (cnt)
    );

    dll_tap_encoder #(.W(W), .MID(MID), .CHECK_STEP(1'b1)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_i   (cnt),
        .offset_i ('0),
        .gray_o   (base_gray)
    );

    generate
        for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
            dll_tap_encoder #(.W(W), .MID(MID), .CHECK_STEP(1'b0)) u_enc (
                .clk      (clk),
                .rst_n    (rst_n),
                .base_i   (cnt),
                .offset_i (off_arr[t]),
                .gray_o   (gray_arr[t])
            );
        end
    endgenerate

    assign tap_a_gray = gray_arr[0];
    assign tap_b_gray = gray_arr[1];

    dll_lock_fsm #(.LOCK_STD(LOCK_STD), .LOCK_LJ(LOCK_LJ)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .low_jitter (low_jitter),
        .locked_o   (locked),
        .valid_o    (settings_valid)
    );

    AST_FLAGS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        locked == settings_valid); // R10

endmodule

// File: tb/tb_dll_code_ctrl.sv
module tb_dll_code_ctrl;

    logic       clk = 1'b0;
    logic       rst_n, restart, low_jitter, pd_up, pd_dn;
    logic [6:0] offset_a, offset_b;
    logic [6:0] base_gray, tap_a_gray, tap_b_gray;
    logic       locked, settings_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dll_code_ctrl dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .low_jitter(low_jitter),
        .pd_up(pd_up), .pd_dn(pd_dn), .offset_a(offset_a), .offset_b(offset_b),
        .base_gray(base_gray), .tap_a_gray(tap_a_gray), .tap_b_gray(tap_b_gray),
        .locked(locked), .settings_valid(settings_valid)
    );

    function automatic logic [6:0] gray(input int b);
        logic [6:0] v;
        v = 7'(b);
        return v ^ (v >> 1);
    endfunction

    function automatic int clamp(input int b, input logic [6:0] off);
        int s;
        s = b + int'($signed(off));
        if (s < 0) s = 0;
        if (s > 127) s = 127;
        return s;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; restart = 1'b0; low_jitter = 1'b0;
        pd_up = 1'b0; pd_dn = 1'b0; offset_a = 7'd5; offset_b = 7'h7D;
        step(3);
        chk("R1 base_gray", base_gray, 7'h60);
        chk("R1 tap_a_gray", tap_a_gray, 7'h60);
        chk("R1 tap_b_gray", tap_b_gray, 7'h60);
        chk("R1 locked", locked, 0);
        chk("R1 settings_valid", settings_valid, 0);
    endtask

    task automatic t_lock_normal;
        rst_n = 1'b1;
        step(255);
        chk("R6 locked at 255", locked, 0);
        chk("R10 valid at 255", settings_valid, 0);
        step(1);
        chk("R6 locked at 256", locked, 1);
        chk("R10 valid at 256", settings_valid, 1);
    endtask

    task automatic t_restart;
        restart = 1'b1;
        step(1);
        restart = 1'b0;
        chk("R8 drop", locked, 0);
        step(255);
        chk("R8 locked at 255", locked, 0);
        step(1);
        chk("R8 locked at 256", locked, 1);
    endtask

    task automatic t_mode_change;
        low_jitter = 1'b1;
        step(1);
        chk("R9 drop", locked, 0);
        step(1279);
        chk("R9 locked at 1279", locked, 0);
        chk("R10 valid at 1279", settings_valid, 0);
        step(1);
        chk("R9 locked at 1280", locked, 1);
    endtask

    task automatic t_lock_lowjit;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1279);
        chk("R7 locked at 1279", locked, 0);
        step(1);
        chk("R7 locked at 1280", locked, 1);
        chk("R10 valid at 1280", settings_valid, 1);
    endtask

    task automatic t_track;
        pd_up = 1'b1;
        step(1);
        pd_up = 1'b0;
        chk("R4 lag one edge", base_gray, gray(64));
        step(1);
        chk("R4 base after up", base_gray, gray(65));
        pd_up = 1'b1; pd_dn = 1'b1;
        step(3);
        pd_up = 1'b0; pd_dn = 1'b0;
        step(2);
        chk("R2 hold both high", base_gray, gray(65));
        pd_dn = 1'b1;
        step(1);
        pd_dn = 1'b0;
        step(1);
        chk("R2 down step", base_gray, gray(64));
    endtask

    task automatic t_saturate;
        logic [6:0] prev;
        int bad = 0;
        prev = base_gray;
        pd_up = 1'b1;
        for (int i = 0; i < 80; i++) begin
            step(1);
            if ($countones(prev ^ base_gray) > 1) bad++;
            prev = base_gray;
        end
        pd_up = 1'b0;
        step(1);
        chk("R3 saturate high", base_gray, gray(127));
        chk("R11 one bit per step up", bad, 0);
        pd_dn = 1'b1;
        for (int i = 0; i < 140; i++) begin
            step(1);
            if ($countones(prev ^ base_gray) > 1) bad++;
            prev = base_gray;
        end
        pd_dn = 1'b0;
        step(1);
        chk("R3 saturate low", base_gray, gray(0));
        chk("R11 one bit per step down", bad, 0);
    endtask

    task automatic t_offsets;
        pd_up = 1'b1;
        step(40);
        pd_up = 1'b0;
        offset_a = 7'd5; offset_b = 7'h7D;
        step(1);
        chk("R5 tap_a +5", tap_a_gray, gray(clamp(40, 7'd5)));
        chk("R5 tap_b -3", tap_b_gray, gray(clamp(40, 7'h7D)));
        offset_a = 7'd63; offset_b = 7'h40;
        step(1);
        chk("R5 tap_a +63", tap_a_gray, gray(103));
        chk("R5 tap_b clamp low", tap_b_gray, gray(0));
        pd_up = 1'b1;
        step(87);
        pd_up = 1'b0;
        offset_a = 7'd10; offset_b = 7'h76;
        step(1);
        chk("R5 tap_a clamp high", tap_a_gray, gray(127));
        chk("R5 tap_b -10", tap_b_gray, gray(117));
        chk("R4 base at top", base_gray, gray(127));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_lock_normal();
        t_restart();
        t_mode_change();
        t_lock_lowjit();
        t_track();
        t_saturate();
        t_offsets();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule